// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O

This block is a peripheral on a narrow processor bus that provides three 8-bit parallel ports and one configuration register. A 2-bit select picks the target: `addr` 0 is port A, 1 is port B, 2 is port C and 3 is the configuration register. An access is qualified by an active-low chip select and by active-low read and write strobes. Strobes are sampled in the system clock domain. A write takes effect when its strobe is released. The data bus is split into input, output and output-enable, so the chip top can build the tri-state pad.

The configuration word sets a direction for four port fields: port A, port B, and the upper and lower nibbles of port C. Port A and the upper nibble of C belong to group A. Port B and the lower nibble of C belong to group B. A word with bit 7 set replaces the configuration and zeroes the output latch of every field it makes an output. A word with bit 7 clear drives one bit of port C to a chosen value and leaves the configuration alone. The handshake modes are not implemented; their mode bits are stored and read back.

Top module: `ppi_triport`

## Requirements
- R1: While `rst` is high, and after it falls, the configuration register holds 0x9B, every port output enable is 0 and every output latch is 0.
- R2: The address selects the target as follows: 0 is port A, 1 is port B, 2 is port C and 3 is the configuration register.
- R3: `bus_oe` is 1 only while `cs_n` and `rd_n` are both low. Whenever `bus_oe` is 0, `bus_out` is 0.
- R4: A write takes effect in the clock cycle after the cycle in which the write strobe (with `cs_n` low) is seen released. A write strobe asserted while `cs_n` is high has no effect.
- R5: A read of the configuration register returns the last configuration word written, or 0x9B after reset, with bit 7 always 1. Mode bits 6:5 and bit 2 are stored as written.
- R6: A configuration write with bit 7 = 1 zeroes the output latch of each field it sets as output. It keeps the latch of each field it sets as input.
- R7: Each direction bit uses 1 for input and 0 for output. Bit 4 controls port A, bit 1 controls port B, bit 3 controls port C bits 7:4 and bit 0 controls port C bits 3:0. An output enable is all ones for an output field and all zeros for an input field.
- R8: A read of port A while it is an input returns the pin value captured in the first cycle of the read strobe. The value is held even if the pins change while the strobe stays low.
- R9: A read of an input nibble of port C returns the live pin value in every cycle of the read.
- R10: A configuration write with bit 7 = 0 sets port C bit `data[3:1]` to `data[0]` and leaves the configuration register unchanged.
- R11: A read of an output-configured field returns its output latch. Writes to a port's data address load its latch whatever its direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target select |
| bus_in | input | 8 | Write data from the processor |
| bus_out | output | 8 | Read data to the processor |
| bus_oe | output | 1 | Drive enable for the data bus pads |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A drive enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B drive enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C drive enable, per nibble |

## Verification
The assertions assume that the processor never asserts the read and write strobes together. They also assume that `addr` and `bus_in` stay steady for the whole time a write strobe is low, so the captured address and data are those of that access. The stimulus keeps to these rules. Each bus task lowers only one strobe, holds address and data until the strobe rises, and releases chip select together with the strobe. Pin inputs change only in the middle of a read, and only to exercise the difference between the latched port A path and the live port C path.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PW = 8;
  localparam int NW = PW / 2;
  localparam int BW = $clog2(PW);
  localparam logic [PW-1:0] RESET_CW = 8'h9B;
  localparam int CW_FLAG = 7;
  localparam int CW_A_IN = 4;
  localparam int CW_CU_IN = 3;
  localparam int CW_B_IN = 1;
  localparam int CW_CL_IN = 0;

  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CW = 2'd3} sel_e;

  // Mask of port C bits that keep their latch on a mode write (input nibbles)
  function automatic logic [PW-1:0] pc_keep(input logic [PW-1:0] cw);
    return {{NW{cw[CW_CU_IN]}}, {NW{cw[CW_CL_IN]}}};
  endfunction

  function automatic logic [PW-1:0] field_oe(input logic in_bit);
    return in_bit ? '0 : '1;
  endfunction

  function automatic logic [PW-1:0] read_mux(
      input sel_e sel, input logic [PW-1:0] cw,
      input logic [PW-1:0] pa_q, input logic [PW-1:0] pa_view,
      input logic [PW-1:0] pb_q, input logic [PW-1:0] pb_pin,
      input logic [PW-1:0] pc_q, input logic [PW-1:0] pc_pin);
    logic [PW-1:0] r;
    logic [PW-1:0] m;
    case (sel)
      SEL_A: r = cw[CW_A_IN] ? pa_view : pa_q;
      SEL_B: r = cw[CW_B_IN] ? pb_pin : pb_q;
      SEL_C: begin
        m = pc_keep(cw);
        r = (pc_pin & m) | (pc_q & ~m);
      end
      default: r = cw | (PW'(1) << CW_FLAG);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ppi_strobe.sv
module ppi_strobe
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] din,
  output logic          rd_act,
  output logic          rd_first,
  output logic          wr_commit,
  output sel_e          wr_sel,
  output logic [PW-1:0] wr_data
);
  logic rd_q, wr_q, wr_act;

  assign rd_act = !cs_n && !rd_n;
  assign wr_act = !cs_n && !wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      wr_sel  <= SEL_A;
      wr_data <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (wr_act) begin
        wr_sel  <= sel_e'(addr);
        wr_data <= din;
      end
    end
  end

  assign rd_first  = rd_act && !rd_q;
  assign wr_commit = wr_q && !wr_act;

  // R4: one release gives exactly one commit pulse
  p_commit_single_r4: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_commit,
  input  sel_e          wr_sel,
  input  logic [PW-1:0] wr_data,
  input  logic          pa_cap,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] cw_q,
  output logic [PW-1:0] pa_q,
  output logic [PW-1:0] pb_q,
  output logic [PW-1:0] pc_q,
  output logic [PW-1:0] pa_hold,
  output logic          mode_evt,
  output logic          bsr_evt
);
  logic cw_sel;
  logic [BW-1:0] bsr_idx;

  assign cw_sel   = wr_commit && (wr_sel == SEL_CW);
  assign mode_evt = cw_sel && wr_data[CW_FLAG];
  assign bsr_evt  = cw_sel && !wr_data[CW_FLAG];
  assign bsr_idx  = wr_data[BW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q    <= RESET_CW;
      pa_q    <= '0;
      pb_q    <= '0;
      pc_q    <= '0;
      pa_hold <= '0;
    end else begin
      if (pa_cap) pa_hold <= pa_in;
      if (wr_commit) begin
        case (wr_sel)
          SEL_A: pa_q <= wr_data;
          SEL_B: pb_q <= wr_data;
          SEL_C: pc_q <= wr_data;
          default: begin
            if (mode_evt) begin
              cw_q <= wr_data;
              if (!wr_data[CW_A_IN]) pa_q <= '0;
              if (!wr_data[CW_B_IN]) pb_q <= '0;
              pc_q <= pc_q & pc_keep(wr_data);
            end else begin
              pc_q[bsr_idx] <= wr_data[0];
            end
          end
        endcase
      end
    end
  end

  // R5: the stored configuration always carries the mode flag
  p_cw_flag_r5: assert property (@(posedge clk) disable iff (rst) cw_q[CW_FLAG]);
  // R10: a single-bit write leaves the configuration alone
  p_bsr_keeps_cw_r10: assert property (@(posedge clk) disable iff (rst)
    bsr_evt |=> $stable(cw_q));
  // R6: a mode word making port A an output leaves its latch at zero
  p_mode_clears_a_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_evt && !wr_data[CW_A_IN]) |=> (pa_q == '0));
  // R8: the port A capture register moves only on a capture event
  p_pa_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !pa_cap |=> $stable(pa_hold));
endmodule

// File: rtl/ppi_triport.sv
module ppi_triport
  import ppi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] bus_in,
  output logic [PW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  logic          rd_act, rd_first, wr_commit, pa_cap, mode_evt, bsr_evt;
  sel_e          wr_sel, rd_sel;
  logic [PW-1:0] wr_data, cw_q, pa_q, pb_q, pc_q, pa_hold, pa_view;

  ppi_strobe u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(bus_in), .rd_act(rd_act), .rd_first(rd_first),
    .wr_commit(wr_commit), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  assign rd_sel = sel_e'(addr);
  assign pa_cap = rd_first && (rd_sel == SEL_A);

  ppi_regs u_regs (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .wr_sel(wr_sel),
    .wr_data(wr_data), .pa_cap(pa_cap), .pa_in(pa_in), .cw_q(cw_q),
    .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q), .pa_hold(pa_hold),
    .mode_evt(mode_evt), .bsr_evt(bsr_evt)
  );

  // In the capture cycle the pins pass straight through; afterwards the held copy
  assign pa_view = pa_cap ? pa_in : pa_hold;
  assign bus_oe  = rd_act;
  assign bus_out = rd_act ? read_mux(rd_sel, cw_q, pa_q, pa_view, pb_q, pb_in, pc_q, pc_in) : '0;

  assign pa_out = pa_q;
  assign pb_out = pb_q;
  assign pc_out = pc_q;
  assign pa_oe  = field_oe(cw_q[CW_A_IN]);
  assign pb_oe  = field_oe(cw_q[CW_B_IN]);

  for (genvar g = 0; g < 2; g++) begin : g_pc_nib
    localparam int DIRB = (g == 0) ? CW_CL_IN : CW_CU_IN;
    assign pc_oe[g*NW +: NW] = cw_q[DIRB] ? '0 : '1;
  end

  // R3: the bus is quiet unless selected and read
  p_bus_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> (!bus_oe && bus_out == '0));
  // R7: after a mode word, port A drive follows its direction bit
  p_pa_dir_r7: assert property (@(posedge clk) disable iff (rst)
    mode_evt |=> ((pa_oe == '0) == $past(wr_data[CW_A_IN])));
  // R7: after a mode word, the upper C nibble drive follows its direction bit
  p_pcu_dir_r7: assert property (@(posedge clk) disable iff (rst)
    mode_evt |=> ((pc_oe[PW-1:NW] == '0) == $past(wr_data[CW_CU_IN])));
endmodule

// File: tb/sim_ppi_triport.sv
`timescale 1ns/1ps
module sim_ppi_triport;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] bus_in = 8'h00, pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] bus_out, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic bus_oe;

  always #4 clk = ~clk;

  ppi_triport u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit live = 0, done = 0;
  // behavioural reference state
  logic [7:0] m_cw = 8'h9B, m_pa = 0, m_pb = 0, m_pc = 0;
  bit m_rd = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dir_oe(input logic in_bit);
    return in_bit ? 8'h00 : 8'hFF;
  endfunction

  // compare outputs against the model on every clock, away from the edge
  always @(negedge clk) if (live && !done) begin
    chk("R7 pa_oe", pa_oe, dir_oe(m_cw[4]));
    chk("R7 pb_oe", pb_oe, dir_oe(m_cw[1]));
    chk("R7 pc_oe", pc_oe, {dir_oe(m_cw[3])[3:0], dir_oe(m_cw[0])[3:0]});
    chk("R11 pa_out", pa_out, m_pa);
    chk("R11 pb_out", pb_out, m_pb);
    chk("R10 pc_out", pc_out, m_pc);
    chk("R3 bus_oe", {7'd0, bus_oe}, {7'd0, m_rd});
    if (!m_rd) chk("R3 bus_out idle", bus_out, 8'h00);
  end

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_pa = d;
      2'd1: m_pb = d;
      2'd2: m_pc = d;
      default: if (d[7]) begin
        m_cw = d;
        if (!d[4]) m_pa = 0;
        if (!d[1]) m_pb = 0;
        if (!d[3]) m_pc[7:4] = 0;
        if (!d[0]) m_pc[3:0] = 0;
      end else m_pc[d[3:1]] = d[0];
    endcase
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit sel = 1);
    @(posedge clk); #1;
    cs_n = !sel; addr = a; bus_in = d; wr_n = 0;
    @(posedge clk); #1;
    wr_n = 1; cs_n = 1;
    @(posedge clk); #1;
    if (sel) model_write(a, d);
    @(posedge clk); #1;
  endtask

  // v1 in the first strobe cycle, v2 one cycle later after optional pin change
  task automatic bus_rd(input logic [1:0] a, input bit chg, input logic [7:0] npa,
                        input logic [7:0] npc, output logic [7:0] v1, output logic [7:0] v2);
    @(posedge clk); #1;
    cs_n = 0; rd_n = 0; addr = a; m_rd = 1;
    @(negedge clk); v1 = bus_out;
    @(posedge clk); #1;
    if (chg) begin pa_in = npa; pc_in = npc; end
    @(negedge clk); v2 = bus_out;
    @(posedge clk); #1;
    cs_n = 1; rd_n = 1; m_rd = 0;
  endtask

  logic [7:0] v1, v2;

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0; live = 1;
    // R1 R5: reset configuration value with flag
    bus_rd(2'd3, 0, 0, 0, v1, v2);
    chk("R1 reset cw", v2, 8'h9B);
    // R4: write strobe without chip select is ignored
    bus_wr(2'd3, 8'h80, 0);
    bus_rd(2'd3, 0, 0, 0, v1, v2);
    chk("R4 unselected write", v2, 8'h9B);
    // R5 R6: all outputs
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd3, 0, 0, 0, v1, v2);
    chk("R5 cw readback", v2, 8'h80);
    // R2 R11: data addresses
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h7E);
    bus_rd(2'd0, 0, 0, 0, v1, v2); chk("R2 R11 read A", v2, 8'h5A);
    bus_rd(2'd1, 0, 0, 0, v1, v2); chk("R2 R11 read B", v2, 8'hC3);
    bus_rd(2'd2, 0, 0, 0, v1, v2); chk("R2 R11 read C", v2, 8'h7E);
    // R10: single-bit writes on port C
    bus_wr(2'd3, 8'h0F);
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd3, 8'h06);
    bus_rd(2'd2, 0, 0, 0, v1, v2); chk("R10 bit set/reset", v2, 8'hF6);
    bus_rd(2'd3, 0, 0, 0, v1, v2); chk("R10 cw unchanged", v2, 8'h80);
    // R6 R7 R9: upper C input, rest outputs
    bus_wr(2'd3, 8'h88);
    chk("R6 C upper kept lower cleared", pc_out, 8'hF0);
    chk("R6 A cleared", pa_out, 8'h00);
    pc_in = 8'hA5;
    bus_rd(2'd2, 0, 0, 0, v1, v2); chk("R9 mixed C read", v2, 8'hA0);
    // R8: port A input held through the strobe
    bus_wr(2'd3, 8'h92);
    pa_in = 8'h3C; pb_in = 8'h66;
    bus_rd(2'd0, 1, 8'h99, 8'hA5, v1, v2);
    chk("R8 A first cycle", v1, 8'h3C);
    chk("R8 A held", v2, 8'h3C);
    bus_rd(2'd1, 0, 0, 0, v1, v2); chk("R7 B input pins", v2, 8'h66);
    bus_rd(2'd0, 0, 0, 0, v1, v2); chk("R8 A new capture", v2, 8'h99);
    // R9: port C fully input follows pins
    bus_wr(2'd3, 8'h89);
    pc_in = 8'h12;
    bus_rd(2'd2, 1, 8'h99, 8'h34, v1, v2);
    chk("R9 C live first", v1, 8'h12);
    chk("R9 C live after change", v2, 8'h34);
    // R5: mode bits stored
    bus_wr(2'd3, 8'hF4);
    bus_rd(2'd3, 0, 0, 0, v1, v2); chk("R5 mode bits", v2, 8'hF4);
    // R3: read strobe without chip select
    @(posedge clk); #1; rd_n = 0; addr = 2'd3;
    @(negedge clk); chk("R3 unselected read", {bus_oe, bus_out[6:0]}, 8'h00);
    @(posedge clk); #1; rd_n = 1;
    // R1: reset again restores state
    rst = 1; live = 0; m_cw = 8'h9B; m_pa = 0; m_pb = 0; m_pc = 0;
    @(posedge clk); #1; rst = 0; live = 1;
    @(negedge clk); chk("R1 pc_oe after reset", pc_oe, 8'h00);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule